// File: doc/BRIEF.md
# Serial-Loaded Dual-Bank Pull-Low Driver

This block takes a serial bit stream into a chain of storage stages, copies the whole chain into a parallel holding register under control of a strobe, and presents the held pattern on a row of open-drain style outputs. The row is split into equal banks. Each bank has two enables of opposite sense, and both must agree before that bank may drive. The last stage of the chain is brought out so several instances can be chained end to end.

Everything runs on one system clock. A shift request input stands in for a rising edge of the serial clock. The holding register is transparent when the strobe level matches a runtime polarity select. Otherwise it keeps its value. Each output is a pull-low request: when it is 1, the external pin is pulled to ground, and when it is 0 the pin is released. At the system level the polarity select is normally tied high and the enables are normally tied to their inactive levels, which matches the way the pins default when left unconnected.

Top module: `sld_driver`

## Requirements
- R1: While `rst` is high, every shift stage and every held bit clears at each clock edge. So one edge after reset is seen, `pull_low` is all zero and `ser_out` is 0.
- R2: On an edge with `shift_en` high, stage 0 takes `ser_in` and every stage k takes the old value of stage k-1. With `shift_en` low, the stages keep their values.
- R3: `ser_out` always shows the last stage (index WIDTH-1). A bit shifted in appears on `ser_out` after exactly WIDTH shift edges.
- R4: With `latch_pol` = 0, the holding register loads while `latch_strobe` is 0 and keeps its value while `latch_strobe` is 1.
- R5: With `latch_pol` = 1, the holding register loads while `latch_strobe` is 1 and keeps its value while `latch_strobe` is 0.
- R6: A load captures the shift stages as they were before that same edge, so the held bits lag the shift stages by one clock.
- R7: Bank b covers output indices b*WIDTH/BANKS up to (b+1)*WIDTH/BANKS-1. Output index 0 corresponds to shift stage 0. A bank drives only when `bank_en_n[b]` is 0 and `bank_en[b]` is 1. With any other enable combination, all of that bank's outputs are 0.
- R8: In a driving bank, `pull_low[i]` is 1 exactly when held bit i is 1.
- R9: The enables of one bank have no effect on the outputs of any other bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Shift request (serial clock rising edge) |
| ser_in | input | 1 | Serial data into stage 0 |
| ser_out | output | 1 | Last shift stage, for cascading |
| latch_strobe | input | 1 | Holding register strobe |
| latch_pol | input | 1 | Strobe level at which the register loads |
| bank_en_n | input | BANKS | Active-low enable per bank |
| bank_en | input | BANKS | Active-high enable per bank |
| pull_low | output | WIDTH | Pull-to-ground request per output |

## Verification
The bench builds the block with WIDTH = 64 and BANKS = 2. With these values the full 64-edge delay from `ser_in` to `ser_out` can be observed. The split at index 32 between the two banks can also be checked. All sixteen combinations of the two bank enable pairs can be tried, so an enable that reaches into the wrong bank would show up. Both polarity settings are run while shifting goes on, which separates correct holding from a register that loads on the wrong level.

// File: rtl/sld_pkg.sv
package sld_pkg;

    localparam int DEF_WIDTH = 64;
    localparam int DEF_BANKS = 2;

    // Strobe level at which the holding register is open
    typedef enum logic {
        OPEN_ON_LOW  = 1'b0,
        OPEN_ON_HIGH = 1'b1
    } open_lvl_e;

    // Per-bank enable pair
    typedef struct packed {
        logic en_n;
        logic en;
    } bank_ctl_t;

    function automatic logic hold_is_open(open_lvl_e lvl, logic strobe);
        return strobe == logic'(lvl);
    endfunction

    function automatic logic bank_drives(bank_ctl_t c);
        return !c.en_n && c.en;
    endfunction

endpackage

// File: rtl/sld_shift.sv
module sld_shift #(
    parameter int WIDTH = sld_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             ser_in,
    output logic [WIDTH-1:0] stages
);
    logic [WIDTH-1:0] stages_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stages_q <= '0;
        end else if (shift_en) begin
            stages_q <= {stages_q[WIDTH-2:0], ser_in};
        end
    end

    assign stages = stages_q;
endmodule

// File: rtl/sld_hold.sv
module sld_hold #(
    parameter int WIDTH = sld_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic             pol,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    import sld_pkg::*;

    logic [WIDTH-1:0] q_r;
    logic             open_w;
    open_lvl_e        lvl;

    assign lvl    = open_lvl_e'(pol);
    assign open_w = hold_is_open(lvl, strobe);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else if (open_w) begin
            q_r <= d;
        end
    end

    assign q = q_r;
endmodule

// File: rtl/sld_bank_gate.sv
module sld_bank_gate #(
    parameter int WIDTH = sld_pkg::DEF_WIDTH,
    parameter int BANKS = sld_pkg::DEF_BANKS
) (
    input  logic [WIDTH-1:0] held,
    input  logic [BANKS-1:0] en_n,
    input  logic [BANKS-1:0] en,
    output logic [WIDTH-1:0] pull_low
);
    import sld_pkg::*;

    localparam int BANK_W = WIDTH / BANKS;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        bank_ctl_t ctl;
        logic      drive;
        assign ctl.en_n = en_n[b];
        assign ctl.en   = en[b];
        assign drive    = bank_drives(ctl);
        assign pull_low[b*BANK_W +: BANK_W] =
            held[b*BANK_W +: BANK_W] & {BANK_W{drive}};
    end
endmodule

// File: rtl/sld_driver.sv
module sld_driver #(
    parameter int WIDTH = sld_pkg::DEF_WIDTH,
    parameter int BANKS = sld_pkg::DEF_BANKS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             ser_in,
    output logic             ser_out,
    input  logic             latch_strobe,
    input  logic             latch_pol,
    input  logic [BANKS-1:0] bank_en_n,
    input  logic [BANKS-1:0] bank_en,
    output logic [WIDTH-1:0] pull_low
);
    localparam int LAST = WIDTH - 1;

    logic [WIDTH-1:0] sr_q;
    logic [WIDTH-1:0] lat_q;

    sld_shift #(.WIDTH(WIDTH)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .ser_in   (ser_in),
        .stages   (sr_q)
    );

    sld_hold #(.WIDTH(WIDTH)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .strobe (latch_strobe),
        .pol    (latch_pol),
        .d      (sr_q),
        .q      (lat_q)
    );

    sld_bank_gate #(.WIDTH(WIDTH), .BANKS(BANKS)) u_gate (
        .held     (lat_q),
        .en_n     (bank_en_n),
        .en       (bank_en),
        .pull_low (pull_low)
    );

    assign ser_out = sr_q[LAST];
endmodule

// File: rtl/sld_checker.sv
module sld_checker #(
    parameter int WIDTH = sld_pkg::DEF_WIDTH,
    parameter int BANKS = sld_pkg::DEF_BANKS
) (
    input logic             clk,
    input logic             rst,
    input logic             shift_en,
    input logic             ser_in,
    input logic             ser_out,
    input logic             latch_strobe,
    input logic             latch_pol,
    input logic [BANKS-1:0] bank_en_n,
    input logic [BANKS-1:0] bank_en,
    input logic [WIDTH-1:0] pull_low,
    input logic [WIDTH-1:0] sr,
    input logic [WIDTH-1:0] lat
);
    localparam int BANK_W = WIDTH / BANKS;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (sr == '0 && lat == '0));

    p_shift_move_r2: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (sr[0] == $past(ser_in) &&
                      sr[WIDTH-1:1] == $past(sr[WIDTH-2:0])));

    p_shift_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(sr));

    p_cascade_r3: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> ser_out == $past(sr[WIDTH-2]));

    p_hold_closed_r4_r5: assert property (@(posedge clk) disable iff (rst)
        (latch_strobe != latch_pol) |=> $stable(lat));

    p_load_open_r6: assert property (@(posedge clk) disable iff (rst)
        (latch_strobe == latch_pol) |=> lat == $past(sr));

    p_only_held_ones_r8: assert property (@(posedge clk) disable iff (rst)
        (pull_low & ~lat) == '0);

    for (genvar b = 0; b < BANKS; b++) begin : g_chk
        p_bank_off_r7: assert property (@(posedge clk) disable iff (rst)
            !(!bank_en_n[b] && bank_en[b]) |->
                pull_low[b*BANK_W +: BANK_W] == '0);
        p_bank_on_r9: assert property (@(posedge clk) disable iff (rst)
            (!bank_en_n[b] && bank_en[b]) |->
                pull_low[b*BANK_W +: BANK_W] == lat[b*BANK_W +: BANK_W]);
    end
endmodule

bind sld_driver sld_checker #(.WIDTH(WIDTH), .BANKS(BANKS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .shift_en     (shift_en),
    .ser_in       (ser_in),
    .ser_out      (ser_out),
    .latch_strobe (latch_strobe),
    .latch_pol    (latch_pol),
    .bank_en_n    (bank_en_n),
    .bank_en      (bank_en),
    .pull_low     (pull_low),
    .sr           (sr_q),
    .lat          (lat_q)
);

// File: tb/sld_driver_tb.sv
module sld_driver_tb;
    localparam int W  = 64;
    localparam int NB = 2;
    localparam int BW = W / NB;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          shift_en = 1'b0;
    logic          ser_in = 1'b0;
    logic          ser_out;
    logic          latch_strobe = 1'b1;
    logic          latch_pol = 1'b1;
    logic [NB-1:0] bank_en_n = '0;
    logic [NB-1:0] bank_en = '1;
    logic [W-1:0]  pull_low;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_tag = "R1";

    // Reference state: queue index 0 is the newest bit
    bit ref_sr[$];
    bit ref_lat[W];

    always #4 clk = ~clk;

    sld_driver #(.WIDTH(W), .BANKS(NB)) u_dut (
        .clk(clk), .rst(rst), .shift_en(shift_en), .ser_in(ser_in),
        .ser_out(ser_out), .latch_strobe(latch_strobe), .latch_pol(latch_pol),
        .bank_en_n(bank_en_n), .bank_en(bank_en), .pull_low(pull_low)
    );

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_pull();
        logic [W-1:0] e;
        for (int i = 0; i < W; i++) begin
            int b = i / BW;
            e[i] = ref_lat[i] && !bank_en_n[b] && bank_en[b];
        end
        return e;
    endfunction

    initial begin
        for (int i = 0; i < W; i++) ref_sr.push_back(1'b0);
    end

    // Behavioural model, updated at the same edge as the design
    always @(posedge clk) begin
        if (rst) begin
            foreach (ref_sr[i]) ref_sr[i] = 1'b0;
            foreach (ref_lat[i]) ref_lat[i] = 1'b0;
        end else begin
            if (latch_strobe == latch_pol)
                for (int i = 0; i < W; i++) ref_lat[i] = ref_sr[i];
            if (shift_en) begin
                ref_sr.push_front(ser_in);
                void'(ref_sr.pop_back());
            end
        end
    end

    // Compare on every clock, away from the edge
    always @(posedge clk) begin
        #2;
        if (!done) begin
            chk({cur_tag, " R8 outputs"}, pull_low, exp_pull());
            chk("R3 ser_out", {{(W-1){1'b0}}, ser_out},
                {{(W-1){1'b0}}, ref_sr[W-1]});
        end
    end

    task automatic step(bit se, bit si, bit ls);
        @(negedge clk);
        shift_en = se;
        ser_in = si;
        latch_strobe = ls;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs cleared by reset even with both banks enabled
        chk("R1 reset outputs", pull_low, '0);
        chk("R1 reset ser_out", {{(W-1){1'b0}}, ser_out}, '0);
        rst = 1'b0;

        // R2, R6: transparent on high strobe, shift a pattern with gaps
        cur_tag = "R2 R6";
        latch_pol = 1'b1;
        for (int i = 0; i < 80; i++) step((i % 5) != 4, ((i * 7) % 3) == 0, 1'b1);

        // R3: single marker travels to the last stage after W shifts
        cur_tag = "R3";
        step(1'b1, 1'b1, 1'b1);
        for (int i = 0; i < W + 4; i++) step(1'b1, 1'b0, 1'b1);

        // R5: polarity high, strobe low holds while shifting continues
        cur_tag = "R5";
        for (int i = 0; i < 20; i++) step(1'b1, i[0], 1'b1);
        for (int i = 0; i < 30; i++) step(1'b1, i[1], 1'b0);
        step(1'b0, 1'b0, 1'b1);

        // R4: polarity low, strobe high holds, strobe low loads
        cur_tag = "R4";
        latch_pol = 1'b0;
        for (int i = 0; i < 30; i++) step(1'b1, (i % 3) == 1, 1'b1);
        for (int i = 0; i < 20; i++) step(1'b1, (i % 4) == 0, 1'b0);
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b1);

        // R7, R9: every enable combination across both banks
        cur_tag = "R7 R9";
        latch_pol = 1'b1;
        for (int i = 0; i < W; i++) step(1'b1, (i % 3) != 2, 1'b1);
        step(1'b0, 1'b0, 1'b0);
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            bank_en_n = {c[3], c[1]};
            bank_en   = {c[2], c[0]};
            repeat (2) @(negedge clk);
        end

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule